// File: doc/BRIEF.md
# Path Signal Label and Unequipped Monitor

This block watches the path overhead of a higher-order container once per frame. On every frame strobe it takes the received signal label byte, the path trace byte, the network-operator byte and a one-bit flag that says the frame had parity errors. It then keeps a filtered copy of the signal label that changes only after a new value has been stable for a selectable number of frames. It also reports three conditions: the label does not match a programmed expected value, the container carries an all-ones indication, or the path is unequipped.

The accepted label is the stored label that software reads. The single-cycle change flag tells a neighbour that this stored value has just been replaced. The two defect flags are filtered in both directions, so a single disturbed frame neither raises nor drops them. While either defect flag is active, the mismatch flag is held low.

Top module: `c2_label_mon`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the accepted label is 0x00 and the change, mismatch, all-ones and unequipped flags are all low.
- R2: A received label that differs from the accepted label replaces it on the frame strobe where it has been received in 3 consecutive frames (persist_sel = 0) or in 5 consecutive frames (persist_sel = 1). Any frame with a different value restarts the count, and that frame counts as the first frame of its own run.
- R3: label_chg is high for exactly one cycle, the cycle after the strobe edge that replaced the accepted label. It stays low when the accepted label does not change.
- R4: mismatch is high when the accepted label differs from exp_label and the accepted label is neither 0x00 nor 0x01.
- R5: mismatch is low whenever vc_ais or unequipped is high.
- R6: vc_ais rises on the 5th consecutive frame whose received label is all ones (0xFF).
- R7: Once vc_ais is set, it falls on the 5th consecutive frame whose received label is not all ones. Any all-ones frame restarts that count.
- R8: unequipped rises on the 5th consecutive frame in which all four of these hold: the received label is 0x00, the trace byte is 0x00, the operator byte is 0x00 and b3_err is low.
- R9: Once unequipped is set, it falls on the 5th consecutive frame in which any of those four conditions fails. A frame in which all four hold restarts that count.
- R10: Cycles without frame_strobe change neither the accepted label nor either defect flag, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_strobe | input | 1 | One cycle per frame; the overhead inputs are valid in that cycle |
| rx_label | input | 8 | Received signal label byte |
| rx_trace | input | 8 | Received path trace byte |
| rx_user | input | 8 | Received network-operator byte |
| b3_err | input | 1 | High when the frame had one or more path parity errors |
| exp_label | input | 8 | Programmed expected signal label |
| persist_sel | input | 1 | 0: accept after 3 frames, 1: accept after 5 frames |
| acc_label | output | 8 | Accepted (stored) signal label |
| label_chg | output | 1 | One-cycle pulse when acc_label is replaced |
| mismatch | output | 1 | Accepted label mismatch |
| vc_ais | output | 1 | All-ones container indication |
| unequipped | output | 1 | Unequipped path indication |

## Verification
The bench builds the block with its default parameters. These are an 8-bit label, acceptance windows of 3 and 5 frames, and set and clear windows of 5 frames for both defects. With these values every label value can be swept through in both persistence settings, with run lengths that fall short of, reach and exceed each window. Directed sequences take each defect flag through its set and clear windows, and break the unequipped run on each of its four conditions in turn. Inputs are scrambled on the cycles between strobes, so the bench shows that those cycles leave the stored state alone.

// File: rtl/c2_label_pkg.sv
`timescale 1ns/1ps
package c2_label_pkg;

   // persistence selection for label acceptance
   typedef enum logic {
      PSEL_SHORT = 1'b0,
      PSEL_LONG  = 1'b1
   } psel_e;

   // defect detector slots
   localparam int DEF_AIS  = 0;
   localparam int DEF_UNEQ = 1;
   localparam int NUM_DEF  = 2;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/c2_label_accept.sv
`timescale 1ns/1ps
module c2_label_accept
   import c2_label_pkg::*;
#(
   parameter int W       = 8,
   parameter int N_SHORT = 3,
   parameter int N_LONG  = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         strobe,
   input  logic [W-1:0] rx,
   input  logic         sel,
   output logic [W-1:0] acc,
   output logic         chg
);
   localparam int N_MAX = imax(N_SHORT, N_LONG);
   localparam int CW    = $clog2(N_MAX + 1);
   localparam logic [CW-1:0] N_MAX_C = CW'(N_MAX);
   localparam logic [CW-1:0] N_SH_C  = CW'(N_SHORT);
   localparam logic [CW-1:0] N_LG_C  = CW'(N_LONG);

   if (N_SHORT < 2) begin : g_bad_short
      $error("c2_label_accept: N_SHORT must be at least 2");
   end
   if (N_LONG < 2) begin : g_bad_long
      $error("c2_label_accept: N_LONG must be at least 2");
   end

   logic [W-1:0]  last_q;
   logic [CW-1:0] run_q;
   logic [CW-1:0] run_nxt;
   logic [CW-1:0] need;
   logic          same;
   logic          take;

   always_comb begin
      same    = (rx == last_q) && (run_q != '0);
      if (!same)
         run_nxt = CW'(1);
      else if (run_q == N_MAX_C)
         run_nxt = run_q;
      else
         run_nxt = run_q + CW'(1);
      need = (psel_e'(sel) == PSEL_LONG) ? N_LG_C : N_SH_C;
      take = strobe && (run_nxt >= need) && (rx != acc);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         last_q <= '0;
         run_q  <= '0;
         acc    <= '0;
         chg    <= 1'b0;
      end else begin
         chg <= take;
         if (strobe) begin
            last_q <= rx;
            run_q  <= run_nxt;
         end
         if (take)
            acc <= rx;
      end
   end

endmodule

// File: rtl/c2_defect_persist.sv
`timescale 1ns/1ps
module c2_defect_persist
   import c2_label_pkg::*;
#(
   parameter int SET_N = 5,
   parameter int CLR_N = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic strobe,
   input  logic cond,
   output logic flag
);
   localparam int N_MAX = imax(SET_N, CLR_N);
   localparam int CW    = $clog2(N_MAX + 1);
   localparam logic [CW-1:0] SET_C = CW'(SET_N);
   localparam logic [CW-1:0] CLR_C = CW'(CLR_N);

   if (SET_N < 1 || CLR_N < 1) begin : g_bad_win
      $error("c2_defect_persist: windows must be at least 1");
   end

   // one counter serves both directions: it counts frames that
   // disagree with the current flag state
   logic [CW-1:0] cnt_q;
   logic [CW-1:0] cnt_inc;
   logic          against;
   logic          limit_hit;

   always_comb begin
      against   = flag ? !cond : cond;
      cnt_inc   = cnt_q + CW'(1);
      limit_hit = flag ? (cnt_inc == CLR_C) : (cnt_inc == SET_C);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
         flag  <= 1'b0;
      end else if (strobe) begin
         if (!against) begin
            cnt_q <= '0;
         end else if (limit_hit) begin
            cnt_q <= '0;
            flag  <= !flag;
         end else begin
            cnt_q <= cnt_inc;
         end
      end
   end

endmodule

// File: rtl/c2_label_mon.sv
`timescale 1ns/1ps
module c2_label_mon
   import c2_label_pkg::*;
#(
   parameter int LBL_W      = 8,
   parameter int ACC_SHORT  = 3,
   parameter int ACC_LONG   = 5,
   parameter int AIS_SET_N  = 5,
   parameter int AIS_CLR_N  = 5,
   parameter int UNEQ_SET_N = 5,
   parameter int UNEQ_CLR_N = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frame_strobe,
   input  logic [LBL_W-1:0] rx_label,
   input  logic [LBL_W-1:0] rx_trace,
   input  logic [LBL_W-1:0] rx_user,
   input  logic             b3_err,
   input  logic [LBL_W-1:0] exp_label,
   input  logic             persist_sel,
   output logic [LBL_W-1:0] acc_label,
   output logic             label_chg,
   output logic             mismatch,
   output logic             vc_ais,
   output logic             unequipped
);
   if (LBL_W < 2) begin : g_bad_width
      $error("c2_label_mon: LBL_W must be at least 2");
   end

   logic [NUM_DEF-1:0] def_cond;
   logic [NUM_DEF-1:0] def_flag;
   logic               exempt;
   logic               suppress;

   c2_label_accept #(
      .W       (LBL_W),
      .N_SHORT (ACC_SHORT),
      .N_LONG  (ACC_LONG)
   ) u_accept (
      .clk    (clk),
      .rst_n  (rst_n),
      .strobe (frame_strobe),
      .rx     (rx_label),
      .sel    (persist_sel),
      .acc    (acc_label),
      .chg    (label_chg)
   );

   assign def_cond[DEF_AIS]  = (rx_label == '1);
   assign def_cond[DEF_UNEQ] = (rx_label == '0) && (rx_trace == '0) &&
                               (rx_user == '0) && !b3_err;

   for (genvar i = 0; i < NUM_DEF; i++) begin : g_def
      localparam int SN = (i == DEF_AIS) ? AIS_SET_N : UNEQ_SET_N;
      localparam int CN = (i == DEF_AIS) ? AIS_CLR_N : UNEQ_CLR_N;
      c2_defect_persist #(
         .SET_N (SN),
         .CLR_N (CN)
      ) u_persist (
         .clk    (clk),
         .rst_n  (rst_n),
         .strobe (frame_strobe),
         .cond   (def_cond[i]),
         .flag   (def_flag[i])
      );
   end

   assign vc_ais     = def_flag[DEF_AIS];
   assign unequipped = def_flag[DEF_UNEQ];

   // labels 0x00 and 0x01 never count as a mismatch
   assign exempt   = (acc_label[LBL_W-1:1] == '0);
   assign suppress = vc_ais || unequipped;
   assign mismatch = (acc_label != exp_label) && !exempt && !suppress;

endmodule

// File: rtl/c2_label_mon_chk.sv
`timescale 1ns/1ps
module c2_label_mon_chk #(
   parameter int W = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         frame_strobe,
   input logic [W-1:0] rx_label,
   input logic [W-1:0] rx_trace,
   input logic [W-1:0] rx_user,
   input logic         b3_err,
   input logic [W-1:0] acc_label,
   input logic         label_chg,
   input logic         mismatch,
   input logic         vc_ais,
   input logic         unequipped
);

   assert_label_from_rx_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_label != $past(acc_label)) |->
         ($past(frame_strobe) && acc_label == $past(rx_label)));

   assert_chg_marks_update_R3: assert property (@(posedge clk) disable iff (!rst_n)
      label_chg |-> (acc_label != $past(acc_label)));

   assert_chg_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
      label_chg |=> !label_chg);

   assert_suppress_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (vc_ais || unequipped) |-> !mismatch);

   assert_ais_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(vc_ais) |-> ($past(frame_strobe) && $past(rx_label) == '1));

   assert_ais_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(vc_ais) |-> ($past(frame_strobe) && $past(rx_label) != '1));

   assert_uneq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(unequipped) |-> ($past(frame_strobe) && $past(rx_label) == '0 &&
                             $past(rx_trace) == '0 && $past(rx_user) == '0 &&
                             !$past(b3_err)));

   assert_uneq_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(unequipped) |-> $past(frame_strobe));

   assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_strobe |=> ($stable(acc_label) && $stable(vc_ais) && $stable(unequipped)));

endmodule

bind c2_label_mon c2_label_mon_chk #(.W(LBL_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .frame_strobe (frame_strobe),
   .rx_label     (rx_label),
   .rx_trace     (rx_trace),
   .rx_user      (rx_user),
   .b3_err       (b3_err),
   .acc_label    (acc_label),
   .label_chg    (label_chg),
   .mismatch     (mismatch),
   .vc_ais       (vc_ais),
   .unequipped   (unequipped)
);

// File: tb/c2_label_mon_bench.sv
`timescale 1ns/1ps
module c2_label_mon_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       frame_strobe = 1'b0;
   logic [7:0] rx_label = 8'h00;
   logic [7:0] rx_trace = 8'h00;
   logic [7:0] rx_user = 8'h00;
   logic       b3_err = 1'b0;
   logic [7:0] exp_label = 8'h00;
   logic       persist_sel = 1'b0;
   logic [7:0] acc_label;
   logic       label_chg;
   logic       mismatch;
   logic       vc_ais;
   logic       unequipped;

   int n_checks = 0;
   int n_errors = 0;

   // requirement-level model state
   logic [7:0] m_last = 8'h00;
   int         m_run = 0;
   logic [7:0] m_acc = 8'h00;
   logic       m_chg = 1'b0;
   logic       m_ais = 1'b0;
   int         m_ais_cnt = 0;
   logic       m_uq = 1'b0;
   int         m_uq_cnt = 0;

   always #10 clk = ~clk;

   c2_label_mon u_c2_label_mon (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_strobe (frame_strobe),
      .rx_label     (rx_label),
      .rx_trace     (rx_trace),
      .rx_user      (rx_user),
      .b3_err       (b3_err),
      .exp_label    (exp_label),
      .persist_sel  (persist_sel),
      .acc_label    (acc_label),
      .label_chg    (label_chg),
      .mismatch     (mismatch),
      .vc_ais       (vc_ais),
      .unequipped   (unequipped)
   );

   task automatic check(input string req, input int act, input int exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic step_defect(input logic cond, inout logic flag, inout int cnt);
      if (flag ? !cond : cond) begin
         cnt++;
         if (cnt == 5) begin
            flag = !flag;
            cnt  = 0;
         end
      end else begin
         cnt = 0;
      end
   endtask

   task automatic check_all();
      logic exp_mm;
      exp_mm = (m_acc != exp_label) && (m_acc > 8'h01) && !m_ais && !m_uq;
      check("R2 accepted label", acc_label, m_acc);
      check("R3 change pulse", label_chg, m_chg);
      if (m_ais || m_uq)
         check("R5 mismatch suppressed", mismatch, 0);
      else
         check("R4 mismatch", mismatch, exp_mm);
      check(m_ais ? "R7 vc_ais held" : "R6 vc_ais", vc_ais, m_ais);
      check(m_uq ? "R9 unequipped held" : "R8 unequipped", unequipped, m_uq);
   endtask

   task automatic frame(input logic [7:0] c2, input logic [7:0] j1,
                        input logic [7:0] n1, input logic err);
      int need;
      logic [7:0] hold_acc;
      logic hold_ais, hold_uq;
      @(negedge clk);
      frame_strobe = 1'b1;
      rx_label = c2;
      rx_trace = j1;
      rx_user  = n1;
      b3_err   = err;
      // model update
      if (m_run != 0 && c2 == m_last) m_run++;
      else m_run = 1;
      m_last = c2;
      need = persist_sel ? 5 : 3;
      m_chg = (m_run >= need) && (c2 != m_acc);
      if (m_chg) m_acc = c2;
      step_defect(c2 == 8'hFF, m_ais, m_ais_cnt);
      step_defect(c2 == 8'h00 && j1 == 8'h00 && n1 == 8'h00 && !err, m_uq, m_uq_cnt);
      @(negedge clk);
      // idle cycle with scrambled inputs (R10)
      frame_strobe = 1'b0;
      rx_label = ~c2;
      rx_trace = 8'h00;
      rx_user  = 8'h00;
      b3_err   = ~err;
      check_all();
      hold_acc = acc_label;
      hold_ais = vc_ais;
      hold_uq  = unequipped;
      @(negedge clk);
      m_chg = 1'b0;
      check("R3 pulse ends", label_chg, 0);
      check("R10 label held off-strobe", acc_label, hold_acc);
      check("R10 defects held off-strobe", {vc_ais, unequipped}, {hold_ais, hold_uq});
   endtask

   task automatic frames(input int n, input logic [7:0] c2, input logic [7:0] j1,
                         input logic [7:0] n1, input logic err);
      for (int k = 0; k < n; k++) frame(c2, j1, n1, err);
   endtask

   initial begin
      #(20ns * 200000);
      n_errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      rx_label = 8'hFF;
      repeat (3) @(negedge clk);
      check("R1 reset label", acc_label, 0);
      check("R1 reset flags", {label_chg, mismatch, vc_ais, unequipped}, 0);
      rst_n = 1'b1;
      rx_label = 8'h00;
      @(negedge clk);
      check("R1 first cycle label", acc_label, 0);
      check("R1 first cycle flags", {label_chg, mismatch, vc_ais, unequipped}, 0);

      // R2 short window, run broken and restarted
      exp_label = 8'h13;
      persist_sel = 1'b0;
      frames(2, 8'h13, 8'h41, 8'h00, 1'b0);
      frame(8'h13, 8'h41, 8'h00, 1'b0);
      frames(2, 8'h22, 8'h41, 8'h00, 1'b0);
      frame(8'h33, 8'h41, 8'h00, 1'b0);
      frames(3, 8'h22, 8'h41, 8'h00, 1'b0);
      // R2 long window
      persist_sel = 1'b1;
      frames(4, 8'h44, 8'h41, 8'h00, 1'b0);
      frame(8'h44, 8'h41, 8'h00, 1'b0);
      // R4 exempt values
      persist_sel = 1'b0;
      frames(3, 8'h01, 8'h41, 8'h00, 1'b0);
      frames(3, 8'h00, 8'h41, 8'h00, 1'b0);
      // R6 / R7 all-ones indication with restart of clear count
      frames(6, 8'hFF, 8'h41, 8'h00, 1'b0);
      frames(4, 8'h13, 8'h41, 8'h00, 1'b0);
      frame(8'hFF, 8'h41, 8'h00, 1'b0);
      frames(5, 8'h13, 8'h41, 8'h00, 1'b0);
      // R8: each condition breaks the run once
      frames(4, 8'h00, 8'h00, 8'h00, 1'b0);
      frame(8'h00, 8'h00, 8'h00, 1'b1);
      frames(4, 8'h00, 8'h00, 8'h00, 1'b0);
      frame(8'h00, 8'h07, 8'h00, 1'b0);
      frames(4, 8'h00, 8'h00, 8'h00, 1'b0);
      frame(8'h00, 8'h00, 8'h09, 1'b0);
      frames(4, 8'h00, 8'h00, 8'h00, 1'b0);
      frame(8'h05, 8'h00, 8'h00, 1'b0);
      frames(5, 8'h00, 8'h00, 8'h00, 1'b0);
      // R9 clear with restart
      frames(3, 8'h00, 8'h00, 8'h00, 1'b1);
      frame(8'h00, 8'h00, 8'h00, 1'b0);
      frames(5, 8'h00, 8'h00, 8'h00, 1'b1);
      frames(5, 8'h13, 8'h41, 8'h00, 1'b0);

      // sweep of all label values, both windows, run lengths 1..6
      for (int s = 0; s < 2; s++) begin
         persist_sel = s[0];
         for (int v = 0; v < 256; v++) begin
            exp_label = 8'(v * 37 + s);
            frames(1 + (v % 6), 8'(v), (v % 7 == 0) ? 8'h00 : 8'(v),
                   (v % 5 == 0) ? 8'h00 : 8'h01, (v % 3 == 0));
         end
      end

      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule